// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line. It samples the line at sixteen times the bit rate. The sample strobe comes from a programmable divider that runs on the system clock. A character is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. Spurious edges are filtered out by voting. A start edge is only taken after the line has been high for a minimum run, and then confirmed by three samples. Every later bit is decided by the majority of three samples near the middle of the bit.

Each finished character is placed in a holding register, and the block raises a set of status flags: data ready, overrun, noise, framing error, parity error and receiver busy. The host reads `rx_data` and then pulses `clr_flags`. That pulse empties the holding register status and clears the error flags. The input is passed through a synchronizer before sampling. All outputs are registered.

Top module: `serial_rx_core`

## Requirements
- R1: A sample strobe occurs once every `divisor` system clocks. A divisor of 0 or 1 gives a strobe every clock. Characters decode correctly at any divisor, for example 4, 6 and 1.
- R2: A low sample can begin a start bit; call it sample 1. The start bit is accepted only if at least two of samples 3, 5 and 7 are low. Otherwise it is dropped, and `data_full` stays 0.
- R3: A low sample begins a start search only if at least 3 consecutive high samples came just before it.
- R4: Each data bit and the stop bit take the majority of samples 8, 9 and 10 of that bit. Data arrives least significant bit first. When `mode9`=1, 9 bits are received into `rx_data[8:0]`. When `mode9`=0, 8 bits go into `rx_data[7:0]` and `rx_data[8]` reads 0.
- R5: When `par_en`=1, the top received data bit is the parity bit and stays in `rx_data`. `parity_err` is set when the XOR of all received data bits differs from `par_odd` (0 = even, 1 = odd).
- R6: A stop bit that votes 0 sets `frame_err`. The data is still loaded and `data_full` is still set.
- R7: `noise_err` is set together with `data_full` if the three votes of any voted bit (start, data or stop) were not all equal. A majority vote still gives the correct value.
- R8: If a character completes while `data_full`=1, `rx_data`, `noise_err`, `frame_err` and `parity_err` keep their values and `overrun` is set.
- R9: A one-cycle `clr_flags` pulse clears `data_full`, `overrun`, `noise_err`, `frame_err` and `parity_err`, and leaves `rx_data` unchanged.
- R10: `rx_active` sets when a low sample begins a start search. It clears after 160 consecutive high samples, or 176 when `mode9`=1 (one idle character).
- R11: After reset, all flags and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 13 | System clocks per sample strobe |
| mode9 | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rx_in | input | 1 | Asynchronous serial line |
| clr_flags | input | 1 | Pulse: clear data-ready and error flags |
| rx_data | output | 9 | Holding register |
| data_full | output | 1 | Holding register holds an unread character |
| overrun | output | 1 | Character lost because holding register was full |
| noise_err | output | 1 | Vote disagreement seen in the last loaded character |
| frame_err | output | 1 | Stop bit sampled low |
| parity_err | output | 1 | Parity mismatch |
| rx_active | output | 1 | Reception in progress |

## Verification
The hardest cases to reach from the ports are the ones where only one of the three votes is disturbed. The bench's bit timing is not aligned to the design's sample phase. The bench therefore places a glitch one sample wide on the centre sample of a data or stop bit, and a glitch two samples wide around sample 5 of the start bit. Either way, exactly one vote is corrupted whatever the phase offset. The idle-run rule is reached with a break that keeps the line low past the stop bit, followed by a high pulse only two samples long before the next low edge. This leaves the run counter below its threshold. Overrun combined with noise is reached by sending a glitched character while the first one is still unread.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int SPB      = 16;  // samples per bit
  localparam int IDLE_RUN = 3;   // high samples needed before a start edge
  localparam int ST_V0 = 3, ST_V1 = 5, ST_V2 = 7;   // start-bit vote samples
  localparam int BT_V0 = 8, BT_V1 = 9, BT_V2 = 10;  // data/stop vote samples
  localparam int HI_W  = $clog2(11 * SPB + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   nxt;

  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (nxt >= {1'b0, divisor}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= nxt[DIV_W-1:0];
      tick <= 1'b0;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor > 1) |=> (!tick || !$stable(divisor)));
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_s,
  input  logic       mode9,
  output logic       done,
  output logic [8:0] word,
  output logic       stop_ok,
  output logic       noise,
  output logic       cand,
  output logic       idle_hit
);
  rx_state_t       st;
  logic [4:0]      ph, nph, s_a, s_b, s_c;
  logic [3:0]      bitn, nlast;
  logic            v0, v1, vote, mixed, nacc;
  logic [8:0]      sh;
  logic [HI_W-1:0] hi_cnt, idle_lim;

  assign nph      = ph + 5'd1;
  assign s_a      = (st == ST_START) ? 5'(ST_V0) : 5'(BT_V0);
  assign s_b      = (st == ST_START) ? 5'(ST_V1) : 5'(BT_V1);
  assign s_c      = (st == ST_START) ? 5'(ST_V2) : 5'(BT_V2);
  assign vote     = maj3(v0, v1, rx_s);
  assign mixed    = !((v0 == v1) && (v1 == rx_s));
  assign nlast    = mode9 ? 4'd8 : 4'd7;
  assign idle_lim = mode9 ? HI_W'(11 * SPB) : HI_W'(10 * SPB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HUNT; ph <= '0; bitn <= '0; v0 <= 1'b0; v1 <= 1'b0;
      sh <= '0; nacc <= 1'b0; hi_cnt <= '0; done <= 1'b0; cand <= 1'b0;
      idle_hit <= 1'b0; word <= '0; stop_ok <= 1'b0; noise <= 1'b0;
    end else begin
      done <= 1'b0; cand <= 1'b0; idle_hit <= 1'b0;
      if (tick) begin
        if (rx_s) begin
          if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
          idle_hit <= (hi_cnt + 1'b1 == idle_lim);
        end else begin
          hi_cnt <= '0;
        end
        if (st == ST_HUNT) begin
          if (!rx_s && hi_cnt >= HI_W'(IDLE_RUN)) begin
            st <= ST_START; ph <= 5'd1; cand <= 1'b1; nacc <= 1'b0;
          end
        end else begin
          if (nph == s_a) v0 <= rx_s;
          if (nph == s_b) v1 <= rx_s;
          if (nph == s_c) begin
            case (st)
              ST_START: if (vote) st <= ST_HUNT; else nacc <= mixed;
              ST_DATA: begin
                sh   <= {vote, sh[8:1]};
                nacc <= nacc | mixed;
              end
              default: begin
                done    <= 1'b1;
                stop_ok <= vote;
                noise   <= nacc | mixed;
                word    <= mode9 ? sh : {1'b0, sh[8:1]};
                st      <= ST_HUNT;
              end
            endcase
          end
          if (nph == 5'(SPB)) begin
            ph <= '0;
            if (st == ST_START) begin
              st <= ST_DATA; bitn <= '0;
            end else if (bitn == nlast) begin
              st <= ST_STOP;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end else begin
            ph <= nph;
          end
        end
      end
    end
  end

  assert_start_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    cand |-> $past(hi_cnt) >= HI_W'(IDLE_RUN));
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic [8:0] word,
  input  logic       stop_ok,
  input  logic       noise,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       clr,
  input  logic       cand,
  input  logic       idle_hit,
  output logic [8:0] rx_data,
  output logic       data_full,
  output logic       overrun,
  output logic       noise_err,
  output logic       frame_err,
  output logic       parity_err,
  output logic       rx_active
);
  logic perr;
  assign perr = par_en && ((^word) != par_odd);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0; data_full <= 1'b0; overrun <= 1'b0; noise_err <= 1'b0;
      frame_err <= 1'b0; parity_err <= 1'b0; rx_active <= 1'b0;
    end else begin
      if (clr) begin
        data_full <= 1'b0; overrun <= 1'b0; noise_err <= 1'b0;
        frame_err <= 1'b0; parity_err <= 1'b0;
      end
      if (done) begin
        if (data_full && !clr) begin
          overrun <= 1'b1;
        end else begin
          rx_data    <= word;
          data_full  <= 1'b1;
          noise_err  <= noise;
          frame_err  <= !stop_ok;
          parity_err <= perr;
        end
      end
      if (cand) rx_active <= 1'b1;
      else if (idle_hit) rx_active <= 1'b0;
    end
  end

  assert_overrun_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && data_full && !clr) |=> (overrun && $stable(rx_data) && $stable(frame_err)));
  assert_no_noise_on_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (done && data_full && !clr) |=> $stable(noise_err));
  assert_clear_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !done) |=> (!data_full && !overrun && !noise_err && !frame_err && !parity_err
                        && $stable(rx_data)));
  assert_active_on_start_R10: assert property (@(posedge clk) disable iff (rst)
    cand |=> rx_active);
  assert_full_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> data_full);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DIV_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             mode9,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rx_in,
  input  logic             clr_flags,
  output logic [8:0]       rx_data,
  output logic             data_full,
  output logic             overrun,
  output logic             noise_err,
  output logic             frame_err,
  output logic             parity_err,
  output logic             rx_active
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic       tick, done, stop_ok, noise, cand, idle_hit;
  logic [8:0] word;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
  end

  serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  serial_rx_sampler u_samp (
    .clk(clk), .rst(rst), .tick(tick), .rx_s(sync_q[SYNC_STAGES-1]),
    .mode9(mode9), .done(done), .word(word), .stop_ok(stop_ok),
    .noise(noise), .cand(cand), .idle_hit(idle_hit)
  );

  serial_rx_flags u_flags (
    .clk(clk), .rst(rst), .done(done), .word(word), .stop_ok(stop_ok),
    .noise(noise), .par_en(par_en), .par_odd(par_odd), .clr(clr_flags),
    .cand(cand), .idle_hit(idle_hit), .rx_data(rx_data), .data_full(data_full),
    .overrun(overrun), .noise_err(noise_err), .frame_err(frame_err),
    .parity_err(parity_err), .rx_active(rx_active)
  );
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic [12:0] divisor = 13'd4;
  logic        mode9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, rx = 1'b1, clr = 1'b0;
  logic [8:0]  rx_data;
  logic        data_full, overrun, noise_err, frame_err, parity_err, rx_active;
  int          checks = 0, fails = 0, div_b = 4, cycles = 0;

  always #10 clk = ~clk;

  serial_rx_core u_dut (
    .clk(clk), .rst(rst), .divisor(divisor), .mode9(mode9), .par_en(par_en),
    .par_odd(par_odd), .rx_in(rx), .clr_flags(clr), .rx_data(rx_data),
    .data_full(data_full), .overrun(overrun), .noise_err(noise_err),
    .frame_err(frame_err), .parity_err(parity_err), .rx_active(rx_active)
  );

  // m9, pe, po, data, glitch bit (15 none, 0 start, 1..n data, n+1 stop), stop, exp data, noise, fe, pe
  typedef struct packed {
    logic m9; logic pe; logic po; logic [8:0] d; logic [3:0] gl; logic stopv;
    logic [8:0] ed; logic en; logic efe; logic epe;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0,1'b0,1'b0,9'h055,4'd15,1'b1,9'h055,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,9'h0A3,4'd15,1'b1,9'h0A3,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,9'h1A5,4'd15,1'b1,9'h1A5,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,9'h0FF,4'd15,1'b1,9'h0FF,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,9'h003,4'd15,1'b1,9'h003,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,9'h007,4'd15,1'b1,9'h007,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,9'h007,4'd15,1'b1,9'h007,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,9'h100,4'd15,1'b1,9'h100,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,9'h100,4'd15,1'b1,9'h100,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,9'h05A,4'd3, 1'b1,9'h05A,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,9'h03C,4'd0, 1'b1,9'h03C,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,9'h081,4'd9, 1'b1,9'h081,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,9'h012,4'd15,1'b0,9'h012,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,9'h1FF,4'd15,1'b1,9'h0FF,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx <= v;
    repeat (n * div_b) @(negedge clk);
  endtask

  task automatic send(input logic m9, input logic [8:0] d, input int glitch, input logic stopv);
    int nb;
    nb = m9 ? 9 : 8;
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == nb + 1) ? stopv : d[b-1];
      for (int s = 1; s <= 16; s++) begin
        logic g;
        g = (b == glitch) && ((b == 0) ? (s == 5 || s == 6) : (s == 9));
        rx <= v ^ g;
        repeat (div_b) @(negedge clk);
      end
    end
    hold(1'b1, 4);
  endtask

  task automatic pulse_clr();
    clr <= 1'b1;
    @(negedge clk);
    clr <= 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 data", rx_data, 9'h000);
    chk("R11 flags", {3'b0, data_full, overrun, noise_err, frame_err, parity_err, rx_active}, 9'h000);
    hold(1'b1, 8);

    // R4 R5 R6 R7 vector walk
    foreach (VECS[i]) begin
      mode9 <= VECS[i].m9; par_en <= VECS[i].pe; par_odd <= VECS[i].po;
      @(negedge clk);
      send(VECS[i].m9, VECS[i].d, (VECS[i].gl == 4'd15) ? -1 : int'(VECS[i].gl), VECS[i].stopv);
      chk("R4 data_full", {8'b0, data_full}, 9'h001);
      chk("R4 rx_data", rx_data, VECS[i].ed);
      chk("R7 noise", {8'b0, noise_err}, {8'b0, VECS[i].en});
      chk("R6 framing", {8'b0, frame_err}, {8'b0, VECS[i].efe});
      chk("R5 parity", {8'b0, parity_err}, {8'b0, VECS[i].epe});
      pulse_clr();
      chk("R9 cleared", {8'b0, data_full}, 9'h000);
    end
    mode9 <= 1'b0; par_en <= 1'b0;

    // R10 active until an idle character
    chk("R10 active after frame", {8'b0, rx_active}, 9'h001);
    hold(1'b1, 200);
    chk("R10 idle clears", {8'b0, rx_active}, 9'h000);

    // R2 short low pulse: start rejected
    hold(1'b0, 2);
    hold(1'b1, 30);
    chk("R10 active on low", {8'b0, rx_active}, 9'h001);
    chk("R2 rejected start", {8'b0, data_full}, 9'h000);
    hold(1'b1, 200);
    chk("R10 idle after reject", {8'b0, rx_active}, 9'h000);

    // R8 overrun, R7 no noise on overrun, R9 data kept
    send(1'b0, 9'h011, -1, 1'b1);
    send(1'b0, 9'h022, 2, 1'b1);
    chk("R8 data kept", rx_data, 9'h011);
    chk("R8 overrun", {8'b0, overrun}, 9'h001);
    chk("R7 noise not set on overrun", {8'b0, noise_err}, 9'h000);
    pulse_clr();
    chk("R9 overrun cleared", {8'b0, overrun}, 9'h000);
    chk("R9 data unchanged", rx_data, 9'h011);

    // R6 break, then R3 too-short high run
    hold(1'b0, 170);
    chk("R6 break full", {8'b0, data_full}, 9'h001);
    chk("R6 break framing", {8'b0, frame_err}, 9'h001);
    chk("R6 break data", rx_data, 9'h000);
    pulse_clr();
    hold(1'b1, 2);
    hold(1'b0, 40);
    hold(1'b1, 40);
    chk("R3 no start without idle run", {8'b0, data_full}, 9'h000);

    // R1 other divisors
    divisor <= 13'd6; div_b = 6;
    hold(1'b1, 10);
    send(1'b0, 9'h0C9, -1, 1'b1);
    chk("R1 divisor 6", rx_data, 9'h0C9);
    pulse_clr();
    divisor <= 13'd1; div_b = 1;
    hold(1'b1, 10);
    send(1'b0, 9'h03E, -1, 1'b1);
    chk("R1 divisor 1", rx_data, 9'h03E);
    chk("R1 divisor 1 full", {8'b0, data_full}, 9'h001);
    pulse_clr();
    finish_run();
  end
endmodule